// File: doc/BRIEF.md
# SPI Master with Boot-Time Dummy Clock Preamble

This block is a byte-oriented SPI master for a serial flash. It has one special duty at power-up. When reset is released, it sends a fixed burst of clock pulses on the serial clock while chip select stays inactive. This gives an external clock-switching primitive the edges it needs to move from its internal configuration clock to the clock this block drives. Until that burst is over, the block reports busy and accepts no host request.

After the preamble it works as a plain mode-0 master:
- The serial clock idles low.
- Output data changes on falling edges and goes out most significant bit first.
- The incoming serial data first passes through an input register, and that registered copy is sampled on rising edges.

A host starts a byte with a one-cycle request and receives a one-cycle acknowledge with the received byte. A keep flag given with the request leaves chip select asserted after the byte ends, so several bytes can share one selection.

The half-period of the serial clock is set by a divider input. Each level of the clock lasts `max(div_i,1)+1` system cycles, and the preamble uses the same rate.

Top module: `spi_boot_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cs_n_o` is 1, `sck_o` is 0, `busy_o` is 1 and `ack_o` is 0.
- R2: After reset, exactly PRE_PULSES rising edges appear on `sck_o` with `cs_n_o` held at 1 (default 8; elaboration fails below 3). `busy_o` falls on the cycle the last of these pulses returns low.
- R3: Every level of `sck_o` lasts exactly `max(div_i,1)+1` clock cycles, in the preamble and in transfers alike. The first preamble rise occurs that many cycles after reset release.
- R4: The preamble happens once only. Each later transfer produces exactly 8 rising edges on `sck_o`, and no clock pulse ever occurs with `cs_n_o` at 1 after the preamble.
- R5: `req_i` is ignored on any cycle where `busy_o` is 1, whether in the preamble or in a transfer. An ignored request starts no transfer, changes neither `cs_n_o` nor the transmitted data, and yields no extra acknowledge.
- R6: `sck_o` is 0 whenever `busy_o` is 0. `mosi_o` only changes while `sck_o` is low. At the k-th rising edge of a transfer (k = 1..8), `mosi_o` carries bit 8-k of `tx_i` as captured at acceptance, so bit 7 goes out first.
- R7: `miso_i` passes through a register before use. The bit seen at the k-th rising edge becomes bit 8-k of `rx_o`. `rx_o` holds the whole received byte on the acknowledge cycle.
- R8: For an accepted request, `cs_n_o` is 0 from the next cycle on. The first rise of `sck_o` comes `max(div_i,1)+1` cycles after acceptance. `ack_o` pulses `max(div_i,1)+1` cycles after the last falling edge.
- R9: If `keep_i` is 0 at acceptance, `cs_n_o` returns to 1 in the same cycle as `ack_o`. If `keep_i` is 1, `cs_n_o` stays 0 after the acknowledge until a later byte ends without keep.
- R10: `busy_o` is 1 from the cycle after acceptance until the acknowledge. `ack_o` lasts one cycle and coincides with `busy_o` being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Half-period divider; 0 acts as 1; hold stable while busy |
| req_i | input | 1 | Start one byte when `busy_o` is 0 |
| keep_i | input | 1 | Keep chip select asserted after this byte |
| tx_i | input | BYTE_W | Byte to transmit, captured on acceptance |
| ack_o | output | 1 | One-cycle pulse: byte finished |
| rx_o | output | BYTE_W | Received byte, valid on `ack_o` |
| busy_o | output | 1 | Preamble or transfer in progress |
| sck_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A wrong preamble count or a lost done state shows in the first few hundred cycles after reset. Either the rising-edge tally with chip select high is not eight, or the busy flag falls at the wrong cycle; both are measured exactly against the divider. A slip in the edge counter or the half-period counter during a transfer shows by the acknowledge of the same byte. It appears as a rise count other than eight, a wrong gap between clock levels, or a mis-timed acknowledge. A shift register fault shows as a wrong transmitted or received byte on that same acknowledge.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

    // Controller phases
    typedef enum logic [2:0] {
        ST_PRE   = 3'd0,   // boot dummy clocks, chip select high
        ST_IDLE  = 3'd1,   // waiting for a request
        ST_SETUP = 3'd2,   // chip select low, lead half period
        ST_XFER  = 3'd3,   // shifting edges
        ST_HOLD  = 3'd4    // trailing half period before release
    } ctl_state_e;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_st_t;

    tick_st_t         t_d, t_q;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        lim    = (div_i == '0) ? DIV_W'(1) : div_i;
        at_lim = (t_q.cnt >= lim);
        tick_o = en_i && at_lim;
        t_d    = t_q;
        if (!en_i || at_lim) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miso_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] tx_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              mosi_o,
    output logic [BYTE_W-1:0] rx_o
);

    typedef struct packed {
        logic              miso;   // input register
        logic [BYTE_W-1:0] tx_sr;
        logic [BYTE_W-1:0] rx_sr;
    } sh_st_t;

    sh_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.miso = miso_i;
        if (load_i) begin
            s_d.tx_sr = tx_i;
        end else if (fall_i) begin
            s_d.tx_sr = {s_q.tx_sr[BYTE_W-2:0], 1'b0};
        end
        if (rise_i) begin
            s_d.rx_sr = {s_q.rx_sr[BYTE_W-2:0], s_q.miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mosi_o = s_q.tx_sr[BYTE_W-1];
    assign rx_o   = s_q.rx_sr;

endmodule

// File: rtl/spi_boot_ctrl.sv
module spi_boot_ctrl
    import spi_boot_pkg::*;
#(
    parameter int PRE_PULSES = 8,
    parameter int BYTE_W     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic req_i,
    input  logic keep_i,
    output logic tick_en_o,
    output logic load_o,
    output logic rise_o,
    output logic fall_o,
    output logic sck_o,
    output logic cs_n_o,
    output logic busy_o,
    output logic ack_o
);

    localparam int PRE_EDGES  = 2 * PRE_PULSES;
    localparam int XFER_EDGES = 2 * BYTE_W;
    localparam int MAX_EDGES  = (PRE_EDGES > XFER_EDGES) ? PRE_EDGES : XFER_EDGES;
    localparam int EDGE_W     = $clog2(MAX_EDGES);

    typedef struct packed {
        ctl_state_e        state;
        logic [EDGE_W-1:0] edg;
        logic              sck;
        logic              cs_n;
        logic              keep;
        logic              ack;
    } ctl_st_t;

    ctl_st_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.ack = 1'b0;
        load_o  = 1'b0;
        rise_o  = 1'b0;
        fall_o  = 1'b0;
        unique case (c_q.state)
            ST_PRE: begin
                if (tick_i) begin
                    c_d.sck = ~c_q.sck;
                    if (c_q.edg == EDGE_W'(PRE_EDGES - 1)) begin
                        c_d.state = ST_IDLE;
                        c_d.edg   = '0;
                    end else begin
                        c_d.edg = c_q.edg + EDGE_W'(1);
                    end
                end
            end
            ST_IDLE: begin
                if (req_i) begin
                    c_d.state = ST_SETUP;
                    c_d.cs_n  = 1'b0;
                    c_d.keep  = keep_i;
                    c_d.edg   = '0;
                    load_o    = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tick_i) begin
                    c_d.sck   = 1'b1;
                    c_d.edg   = EDGE_W'(1);
                    c_d.state = ST_XFER;
                    rise_o    = 1'b1;
                end
            end
            ST_XFER: begin
                if (tick_i) begin
                    c_d.sck = ~c_q.sck;
                    rise_o  = ~c_q.sck;
                    fall_o  = c_q.sck;
                    if (c_q.edg == EDGE_W'(XFER_EDGES - 1)) begin
                        c_d.state = ST_HOLD;
                        c_d.edg   = '0;
                    end else begin
                        c_d.edg = c_q.edg + EDGE_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (tick_i) begin
                    c_d.state = ST_IDLE;
                    c_d.ack   = 1'b1;
                    c_d.cs_n  = ~c_q.keep;
                end
            end
            default: begin
                c_d.state = ST_IDLE;
                c_d.sck   = 1'b0;
                c_d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_PRE;
            c_q.cs_n  <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign tick_en_o = (c_q.state != ST_IDLE);
    assign busy_o    = (c_q.state != ST_IDLE);
    assign sck_o     = c_q.sck;
    assign cs_n_o    = c_q.cs_n;
    assign ack_o     = c_q.ack;

endmodule

// File: rtl/spi_boot_master.sv
module spi_boot_master #(
    parameter int DIV_W      = 8,
    parameter int BYTE_W     = 8,
    parameter int PRE_PULSES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              req_i,
    input  logic              keep_i,
    input  logic [BYTE_W-1:0] tx_i,
    output logic              ack_o,
    output logic [BYTE_W-1:0] rx_o,
    output logic              busy_o,
    output logic              sck_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i
);

    // The downstream clock switch needs at least three edges
    if (PRE_PULSES < 3) begin : g_pre_too_short
        $error("PRE_PULSES must be at least 3");
    end

    logic tick, tick_en, load, rise, fall;

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .div_i  (div_i),
        .tick_o (tick)
    );

    spi_boot_ctrl #(.PRE_PULSES(PRE_PULSES), .BYTE_W(BYTE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .req_i     (req_i),
        .keep_i    (keep_i),
        .tick_en_o (tick_en),
        .load_o    (load),
        .rise_o    (rise),
        .fall_o    (fall),
        .sck_o     (sck_o),
        .cs_n_o    (cs_n_o),
        .busy_o    (busy_o),
        .ack_o     (ack_o)
    );

    spi_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .miso_i (miso_i),
        .load_i (load),
        .tx_i   (tx_i),
        .rise_i (rise),
        .fall_i (fall),
        .mosi_o (mosi_o),
        .rx_o   (rx_o)
    );

endmodule

// File: rtl/spi_boot_master_chk.sv
module spi_boot_master_chk #(
    parameter int PRE_PULSES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic ack_o,
    input logic sck_o,
    input logic cs_n_o,
    input logic mosi_o
);

    localparam int CNT_W = $clog2(PRE_PULSES + 2) + 1;

    logic             boot_done_q;
    logic             sck_prev_q;
    logic [CNT_W-1:0] pre_rises_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_done_q <= 1'b0;
            sck_prev_q  <= 1'b0;
            pre_rises_q <= '0;
        end else begin
            sck_prev_q <= sck_o;
            if (!busy_o) begin
                boot_done_q <= 1'b1;
            end
            if (!boot_done_q && sck_o && !sck_prev_q) begin
                pre_rises_q <= pre_rises_q + CNT_W'(1);
            end
        end
    end

    AST_PRE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done_q |-> cs_n_o);                                             // R2

    AST_PRE_COUNT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_done_q && !busy_o) |-> (pre_rises_q == CNT_W'(PRE_PULSES)));   // R2

    AST_NO_CLOCK_WITH_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done_q && sck_o) |-> !cs_n_o);                                  // R4

    AST_SCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o);                                                  // R6

    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && sck_prev_q) |-> $stable(mosi_o));                           // R6

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);                                                    // R10

    AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !busy_o);                                                   // R10

endmodule

bind spi_boot_master spi_boot_master_chk #(.PRE_PULSES(PRE_PULSES)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (busy_o),
    .ack_o  (ack_o),
    .sck_o  (sck_o),
    .cs_n_o (cs_n_o),
    .mosi_o (mosi_o)
);

// File: tb/spi_boot_master_tb_top.sv
`timescale 1ns/1ps
module spi_boot_master_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = 8'd3;
    logic       req_i = 1'b0;
    logic       keep_i = 1'b0;
    logic [7:0] tx_i = 8'h00;
    logic       ack_o;
    logic [7:0] rx_o;
    logic       busy_o;
    logic       sck_o;
    logic       cs_n_o;
    logic       mosi_o;
    logic       miso_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // monitor state
    logic       prev_sck = 1'b0;
    int         pre_rises = 0;
    int         rise_cnt = 0;
    int         last_edge = -1;
    int         first_rise = 0;
    int         last_fall = 0;
    int         bad_half = 0;
    int         exp_half = 4;
    logic [7:0] mosi_cap = 8'h00;
    logic [7:0] miso_byte = 8'h00;
    int         miso_idx = 0;

    spi_boot_master dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .req_i  (req_i),
        .keep_i (keep_i),
        .tx_i   (tx_i),
        .ack_o  (ack_o),
        .rx_o   (rx_o),
        .busy_o (busy_o),
        .sck_o  (sck_o),
        .cs_n_o (cs_n_o),
        .mosi_o (mosi_o),
        .miso_i (miso_i)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int half_of(input int dv);
        return ((dv == 0) ? 1 : dv) + 1;
    endfunction

    // Pin monitor and MISO slave model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_o && !prev_sck) begin
                if (last_edge >= 0 && (cyc - last_edge) != exp_half) bad_half++;
                last_edge = cyc;
                if (cs_n_o) begin
                    pre_rises++;
                end else begin
                    rise_cnt++;
                    if (rise_cnt == 1) first_rise = cyc;
                    mosi_cap = {mosi_cap[6:0], mosi_o};
                end
            end else if (!sck_o && prev_sck) begin
                if (last_edge >= 0 && (cyc - last_edge) != exp_half) bad_half++;
                last_edge = cyc;
                if (!cs_n_o) begin
                    last_fall = cyc;
                    miso_idx++;
                    if (miso_idx < 8) miso_i = miso_byte[7 - miso_idx];
                end
            end
            prev_sck = sck_o;
        end
    end

    task automatic do_xfer(input logic [7:0] tx, input logic [7:0] rxb,
                           input int dv, input bit keep, input bit poke);
        int acc;
        int guard;
        div_i     = 8'(dv);
        exp_half  = half_of(dv);
        miso_byte = rxb;
        miso_idx  = 0;
        miso_i    = rxb[7];
        rise_cnt  = 0;
        mosi_cap  = 8'h00;
        bad_half  = 0;
        last_edge = -1;
        tx_i      = tx;
        keep_i    = keep;
        req_i     = 1'b1;
        acc       = cyc + 1;
        @(negedge clk);
        req_i = 1'b0;
        chk("R10 busy after accept", int'(busy_o), 1);
        chk("R8 cs low after accept", int'(cs_n_o), 0);
        if (poke) begin
            repeat (exp_half * 5) @(negedge clk);
            tx_i  = ~tx;
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
        end
        guard = 0;
        while (!ack_o && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk("R10 ack seen", int'(ack_o), 1);
        chk("R10 not busy at ack", int'(busy_o), 0);
        chk("R4 rises per byte", rise_cnt, 8);
        chk("R6 mosi byte", int'(mosi_cap), int'(tx));
        chk("R7 rx byte", int'(rx_o), int'(rxb));
        chk("R3 half periods", bad_half, 0);
        chk("R8 lead to first rise", first_rise - acc, exp_half);
        chk("R8 ack after last fall", cyc - last_fall, exp_half);
        chk("R9 cs at ack", int'(cs_n_o), keep ? 0 : 1);
        @(negedge clk);
        chk("R10 ack one cycle", int'(ack_o), 0);
        if (poke) begin
            chk("R5 poke started nothing", int'(busy_o), 0);
            chk("R5 poke no cs change", int'(cs_n_o), keep ? 0 : 1);
        end
    endtask

    initial begin
        int rst_cyc;
        int guard;
        exp_half = half_of(3);
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", int'(cs_n_o), 1);
        chk("R1 sck in reset", int'(sck_o), 0);
        chk("R1 busy in reset", int'(busy_o), 1);
        rst_n   = 1'b1;
        rst_cyc = cyc;
        @(negedge clk);
        chk("R1 cs_n after reset", int'(cs_n_o), 1);
        chk("R1 sck after reset", int'(sck_o), 0);
        chk("R1 busy after reset", int'(busy_o), 1);
        chk("R1 ack after reset", int'(ack_o), 0);
        // request during preamble must be ignored
        repeat (10) @(negedge clk);
        tx_i  = 8'hA5;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        guard = 0;
        while (busy_o && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk("R2 preamble pulses", pre_rises, 8);
        chk("R2 preamble cs stayed high", rise_cnt, 0);
        chk("R3 preamble length", cyc - rst_cyc, 16 * exp_half);
        chk("R3 preamble half periods", bad_half, 0);
        repeat (20) @(negedge clk);
        chk("R5 req in preamble ignored busy", int'(busy_o), 0);
        chk("R5 req in preamble ignored cs", int'(cs_n_o), 1);
        chk("R5 req in preamble ignored sck", rise_cnt, 0);

        // directed corners
        do_xfer(8'h80, 8'h01, 0, 1'b0, 1'b0);   // divider 0 acts as 1
        do_xfer(8'h01, 8'h80, 1, 1'b0, 1'b0);
        do_xfer(8'hFF, 8'h00, 2, 1'b0, 1'b1);   // R5 request during transfer
        do_xfer(8'h3C, 8'hC3, 1, 1'b1, 1'b0);   // R9 keep selected
        repeat (7) @(negedge clk);
        chk("R9 cs held between bytes", int'(cs_n_o), 0);
        do_xfer(8'h5A, 8'hA5, 3, 1'b0, 1'b0);   // R9 release
        repeat (7) @(negedge clk);
        chk("R9 cs released", int'(cs_n_o), 1);

        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 30; i++) begin
            do_xfer(8'($urandom), 8'($urandom), int'($urandom % 5),
                    (i == 29) ? 1'b0 : 1'($urandom % 2), 1'b0);
            repeat (int'($urandom % 4)) @(negedge clk);
        end
        chk("R4 no later dummy clocks", pre_rises, 8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule